// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block passes data between two parallel buses, side A and side B, each `W` bits wide (18 by default). Each direction has its own set of three controls: an output enable, a pass-through control, and a capture strobe. When pass-through is asserted, the destination output follows the source input combinationally. When it is deasserted, the destination drives a stored word instead. That word changes only when the capture strobe rises. The two directions share no state, so one side can be loaded while the other passes data straight through.

The capture strobe is an ordinary data input. It is sampled on the free-running system clock `clk`, and its rising edge is found by comparing against the previous sample. No latch is inferred anywhere. Tri-state drivers are represented as a data bus plus a per-bit enable vector. The chip-level pad ring turns these into real tri-state pins. The A-to-B enable is active high. The B-to-A enable is active low.

Top module: `xbus_xcvr`

## Requirements
- R1: While a direction's pass-through control is 1 and its output is enabled, the destination output equals the source input in the same cycle, bit for bit and without inversion.
- R2: While pass-through is 0 and no capture edge occurs, the destination output keeps its stored word, whatever the source input does.
- R3: With pass-through at 0, a capture-strobe level of 1 sampled at a `clk` edge, following a level of 0 at the previous edge, loads the source input into storage at that edge. The output shows the new word from that edge on.
- R4: A falling capture strobe never loads storage. With pass-through at 1, strobe activity in either direction leaves the output transparent.
- R5: When pass-through drops from 1 to 0, storage holds the source word that was present at the last `clk` edge while pass-through was 1.
- R6: The A-to-B enable `ab_oe` is active high. While it is 0, `b_en` is all zeros and `b_out` is all zeros. Storage keeps following its controls while the output is off.
- R7: The B-to-A enable `ba_oe_n` is active low, with 1 meaning disabled. While it is 1, `a_en` and `a_out` are all zeros. In every other respect this direction behaves like A-to-B.
- R8: The two directions are independent. Loading, holding or passing data in one direction does not disturb the other, even when both outputs are enabled.
- R9: Synchronous active-high `rst` clears both stored words to zero. The first strobe level sampled after reset is never treated as an edge, even if the strobe is already high.
- R10: Every bit of an enable vector is equal at all times. The vector is all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock; samples the strobes and updates storage |
| rst | input | 1 | synchronous reset, active high |
| a_in | input | W | data arriving from side A |
| b_in | input | W | data arriving from side B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B pass-through control |
| ab_cp | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass-through control |
| ba_cp | input | 1 | B-to-A capture strobe |
| b_out | output | W | data driven onto side B |
| b_en | output | W | per-bit driver enable for side B |
| a_out | output | W | data driven onto side A |
| a_en | output | W | per-bit driver enable for side A |

## Verification
The hardest case to reach is the strobe already being high when reset is released. To reach it, the bench holds both strobes at 1 throughout reset, with pass-through off and the outputs enabled. It then keeps the strobes high for several cycles and confirms that neither stored word leaves zero. A second subtle case is storage changing while the output is disabled. The bench reaches it by loading a word with the enable off, then turning the enable on in hold mode to reveal what was stored.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // state of a strobe edge detector
    typedef struct packed {
        logic prev;   // strobe level at the last clk edge
        logic seen;   // at least one sample taken since reset
    } edge_st_t;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.seen = 1'b1;
        rise      = st_q.seen & lvl & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int W      = 18,
    parameter bit OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         oe_pin,
    input  logic         le,
    input  logic         cp,
    output logic [W-1:0] dout,
    output logic [W-1:0] den
);

    logic [W-1:0] store_d, store_q;
    logic         cap_rise;
    logic         drive;

    xcvr_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (cp),
        .rise (cap_rise)
    );

    // enable polarity chosen per direction
    generate
        if (OE_LOW) begin : g_oe_low
            assign drive = ~oe_pin;
        end else begin : g_oe_high
            assign drive = oe_pin;
        end
    endgenerate

    always_comb begin
        store_d = store_q;
        if (le) begin
            store_d = din;          // track while transparent
        end else if (cap_rise) begin
            store_d = din;          // capture on strobe rise
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    always_comb begin
        den  = {W{drive}};
        dout = '0;
        if (drive) begin
            dout = le ? din : store_q;
        end
    end

endmodule

// File: rtl/xbus_xcvr.sv
module xbus_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_en,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_en
);

    xcvr_path #(.W(W), .OE_LOW(1'b0)) u_ab (
        .clk    (clk),
        .rst    (rst),
        .din    (a_in),
        .oe_pin (ab_oe),
        .le     (ab_le),
        .cp     (ab_cp),
        .dout   (b_out),
        .den    (b_en)
    );

    xcvr_path #(.W(W), .OE_LOW(1'b1)) u_ba (
        .clk    (clk),
        .rst    (rst),
        .din    (b_in),
        .oe_pin (ba_oe_n),
        .le     (ba_le),
        .cp     (ba_cp),
        .dout   (a_out),
        .den    (a_en)
    );

endmodule

// File: rtl/xbus_xcvr_chk.sv
module xbus_xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe,
    input logic         ab_le,
    input logic         ab_cp,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cp,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_en,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_en
);

    // R1
    ab_transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_oe && ab_le) |-> (b_out == a_in));

    // R7
    ba_transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (!ba_oe_n && ba_le) |-> (a_out == b_in));

    // R2
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ab_oe && $past(ab_oe) && !ab_le
         && !$past(ab_le) && !($past(ab_cp) && !$past(ab_cp, 2)))
        |-> $stable(b_out));

    // R3
    ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ab_oe && !ab_le && !$past(ab_le)
         && $past(ab_cp) && !$past(ab_cp, 2))
        |-> (b_out == $past(a_in)));

    // R7
    ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !ba_oe_n && !ba_le && !$past(ba_le)
         && $past(ba_cp) && !$past(ba_cp, 2))
        |-> (a_out == $past(b_in)));

    // R6
    ab_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ab_oe |-> (b_en == '0 && b_out == '0));

    // R7
    ba_off_chk: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (a_en == '0 && a_out == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ab_oe && !ab_le) |-> (b_out == '0));

    // R10
    en_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (b_en == {W{b_en[0]}}) && (a_en == {W{a_en[0]}}));

endmodule

bind xbus_xcvr xbus_xcvr_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_oe   (ab_oe),
    .ab_le   (ab_le),
    .ab_cp   (ab_cp),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_cp   (ba_cp),
    .b_out   (b_out),
    .b_en    (b_en),
    .a_out   (a_out),
    .a_en    (a_en)
);

// File: tb/tb_xbus_xcvr.sv
module tb_xbus_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 18;
    localparam int NV         = 17;

    typedef struct packed {
        logic         dir;   // 0: A to B, 1: B to A
        logic         oe;    // raw enable pin level
        logic         le;
        logic         cp;
        logic [W-1:0] din;
        logic         en;    // expected enable
        logic [W-1:0] dout;  // expected output
        logic [3:0]   req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 18'h12345, 1'b1, 18'h12345, 4'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 1'b0, 18'h2AAAA, 1'b1, 18'h2AAAA, 4'd1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h15555, 1'b1, 18'h2AAAA, 4'd5},  // R5
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h0F0F0, 1'b1, 18'h2AAAA, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h0F0F0, 1'b1, 18'h0F0F0, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h3FFFF, 1'b1, 18'h0F0F0, 4'd2},
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFFF, 1'b1, 18'h0F0F0, 4'd4},  // R4
        '{1'b0, 1'b1, 1'b1, 1'b1, 18'h00001, 1'b1, 18'h00001, 4'd4},
        '{1'b0, 1'b1, 1'b1, 1'b0, 18'h00002, 1'b1, 18'h00002, 4'd4},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 1'b0, 18'h00000, 4'd6},  // R6
        '{1'b0, 1'b1, 1'b0, 1'b0, 18'h00000, 1'b1, 18'h3FFFF, 4'd6},
        '{1'b1, 1'b0, 1'b1, 1'b0, 18'h1C3A5, 1'b1, 18'h1C3A5, 4'd7},  // R7
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00F00, 1'b1, 18'h1C3A5, 4'd7},
        '{1'b1, 1'b0, 1'b0, 1'b1, 18'h00F00, 1'b1, 18'h00F00, 4'd7},
        '{1'b1, 1'b0, 1'b0, 1'b1, 18'h12121, 1'b1, 18'h00F00, 4'd7},
        '{1'b1, 1'b1, 1'b0, 1'b0, 18'h12121, 1'b0, 18'h00000, 4'd7},
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h00003, 1'b1, 18'h00F00, 4'd7}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_oe = 1'b0, ab_le = 1'b0, ab_cp = 1'b0;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0;
    logic [W-1:0] b_out, b_en, a_out, a_en;

    int n_chk  = 0;
    int n_fail = 0;
    int overlap = 0;
    bit mon_on  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_xcvr #(.W(W)) dut (
        .clk (clk), .rst (rst), .a_in (a_in), .b_in (b_in),
        .ab_oe (ab_oe), .ab_le (ab_le), .ab_cp (ab_cp),
        .ba_oe_n (ba_oe_n), .ba_le (ba_le), .ba_cp (ba_cp),
        .b_out (b_out), .b_en (b_en), .a_out (a_out), .a_en (a_en)
    );

    // both buses driven at once while the table runs would be contention
    always @(negedge clk) begin
        if (mon_on && (|b_en) && (|a_en)) overlap++;
    end

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        // R9: strobes high through reset, outputs enabled, hold mode
        ab_oe = 1'b1; ab_cp = 1'b1; a_in = 18'h3FFFF;
        ba_oe_n = 1'b0; ba_cp = 1'b1; b_in = 18'h2B2B2;
        repeat (3) tick();
        rst = 1'b0;
        repeat (3) tick();
        check("R9", b_out, '0);
        check("R9", a_out, '0);
        check("R10", b_en, '1);
        check("R10", a_en, '1);
        ab_cp = 1'b0; ba_cp = 1'b0; ab_oe = 1'b0; ba_oe_n = 1'b1;
        tick();

        mon_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (!VECS[i].dir) begin
                ab_oe = VECS[i].oe; ab_le = VECS[i].le;
                ab_cp = VECS[i].cp; a_in = VECS[i].din;
                ba_oe_n = 1'b1; ba_le = 1'b0; ba_cp = 1'b0;
            end else begin
                ba_oe_n = VECS[i].oe; ba_le = VECS[i].le;
                ba_cp = VECS[i].cp; b_in = VECS[i].din;
                ab_oe = 1'b0; ab_le = 1'b0; ab_cp = 1'b0;
            end
            tick();
            if (!VECS[i].dir) begin
                check($sformatf("R%0d row %0d", VECS[i].req, i), b_out, VECS[i].dout);
                check($sformatf("R%0d en row %0d", VECS[i].req, i), b_en, {W{VECS[i].en}});
            end else begin
                check($sformatf("R%0d row %0d", VECS[i].req, i), a_out, VECS[i].dout);
                check($sformatf("R%0d en row %0d", VECS[i].req, i), a_en, {W{VECS[i].en}});
            end
        end
        mon_on = 1'b0;
        check("R8 overlap", W'(overlap), '0);

        // R8: both enabled, one transparent while the other holds
        ab_oe = 1'b1; ab_le = 1'b1; a_in = 18'h11111;
        ba_oe_n = 1'b0; ba_le = 1'b0; ba_cp = 1'b0; b_in = 18'h22222;
        tick();
        check("R8", b_out, 18'h11111);
        check("R8", a_out, 18'h00F00);
        // R8: B-to-A captures while A-to-B holds its word
        ab_le = 1'b0; ba_cp = 1'b1; a_in = 18'h33333;
        tick();
        check("R8", a_out, 18'h22222);
        check("R8", b_out, 18'h11111);

        // R9: mid-run reset clears nonzero words
        ba_cp = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R9", b_out, '0);
        check("R9", a_out, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule